// File: doc/BRIEF.md
# Dual-Channel DAC Register Controller

This block is the digital control core of a two-channel voltage-output converter. A serial slave front end shifts in 24-bit command words and hands each complete word over with a one-cycle done strobe, holding a busy flag while a word is still being shifted. The controller decodes the word and keeps two register stages per channel. The staging register takes new codes. The output register drives the converter code. A separate load input can therefore apply both channels at the same instant.

An active-low load input copies every staged code that is waiting into its output register on a falling edge. When the load input is held low, each write passes straight through to the output register. A falling edge on the active-low clear input zeroes both stages of both channels. While the clear input stays low, load activity is ignored, and a word whose shifting is cut by the clear edge is dropped. Commands also set a per-channel power-down mode, turn the reference on or off, and reset the whole block to its power-on state.

Command word layout: bits [23:20] operation, bits [19:16] channel target, bits [15:0] code, left-justified. The `RES_BITS` parameter (12, 14 or 16; default 12) selects how many upper code bits are kept. The remaining low bits are forced to zero.

Top module: `dac_pair_ctrl`

## Requirements
- R1: After rst_n is low at a clock edge, both codes read 0x0000, both power-down modes read 00 and ref_en reads 0.
- R2: Operation 0x1 stores the code in the staging register of the target channel only. The output code stays unchanged while load_n is high.
- R3: Every stored code keeps its upper RES_BITS bits and has its low 16-RES_BITS bits at zero. With RES_BITS=12, a written 0xABCD reads 0xABC0.
- R4: A high-to-low transition of load_n copies each channel with a waiting staged code into its output register on the same clock edge. A channel without waiting data keeps its code.
- R5: While load_n is low, an operation 0x1 write reaches the output code of the target channel in the same cycle as it reaches the staging register.
- R6: Operation 0x2 copies the target staging register to its output. Operation 0x4 writes and copies for the target. Operation 0x3 writes the target and then copies the staging registers of both channels.
- R7: Target 0x0 selects channel A, 0x1 selects B and 0xF selects both. Any other target with operations 0x1 to 0x4, and any operation code outside 0x1 to 0x7, changes nothing.
- R8: A high-to-low transition of clr_n zeroes the staging and output registers of both channels at the next clock edge. Power-down modes and ref_en are not changed.
- R9: While clr_n is low, load_n edges and a held-low load_n move no output code. The staged codes are still kept and are applied by a later load pulse once clr_n is high.
- R10: If clr_n falls while frm_busy is high, the done strobe that ends that word is ignored. The next word is accepted normally.
- R11: Operation 0x5 applies mode bits [5:4] (00 active, 01 1 kOhm to ground, 10 100 kOhm to ground, 11 floating) to each channel whose bit is set in mask bits [1:0] (bit 0 = A, bit 1 = B).
- R12: Operation 0x7 sets ref_en to code bit 0. Nothing else except reset and operation 0x6 changes ref_en.
- R13: Operation 0x6 returns codes, power-down modes and ref_en to their power-on values at the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_busy | input | 1 | High while a command word is being shifted in |
| frm_done | input | 1 | One-cycle strobe: frm_word holds a complete command |
| frm_word | input | 24 | Command word: operation, target, code |
| load_n | input | 1 | Active-low load; edge copies staged codes, low level passes writes through |
| clr_n | input | 1 | Active-low clear; falling edge zeroes both register stages |
| code_a | output | 16 | Output code of channel A |
| code_b | output | 16 | Output code of channel B |
| pd_a | output | 2 | Power-down mode of channel A |
| pd_b | output | 2 | Power-down mode of channel B |
| ref_en | output | 1 | Reference enable |

## Verification
The decode is tried with one table of command words. It mixes staging-only writes, explicit copies, write-and-copy on one channel and on both, pass-through with load_n held low, and words with an unused target or operation. Together these separate the staging stage from the output stage and show which channel each target reaches. Directed sequences then stage different codes on both channels before one load pulse, which shows that the updates happen at the same moment and that a channel without waiting data is left alone. A clear with staged data pending and load activity while clear is held shows that the clear gate blocks loads and that the staged codes survive it. A clear edge in the middle of a word shows the abort, and a second word shows that the abort is not sticky.

// File: rtl/dpc_pkg.sv
// Shared constants, operation codes and the decoded-command record for
// the dual-channel DAC register controller.
package dpc_pkg;
    localparam int CODE_W  = 16;
    localparam int FRAME_W = 24;
    localparam int NCH     = 2;

    // Operation field, word bits [23:20]
    localparam logic [3:0] OP_WR_IN      = 4'h1;
    localparam logic [3:0] OP_UPD        = 4'h2;
    localparam logic [3:0] OP_WR_UPD_ALL = 4'h3;
    localparam logic [3:0] OP_WR_UPD     = 4'h4;
    localparam logic [3:0] OP_PWR        = 4'h5;
    localparam logic [3:0] OP_SRST       = 4'h6;
    localparam logic [3:0] OP_REF        = 4'h7;

    localparam logic [3:0] TGT_ALL = 4'hF;

    typedef enum logic [1:0] {
        PD_ON    = 2'b00,
        PD_1K    = 2'b01,
        PD_100K  = 2'b10,
        PD_FLOAT = 2'b11
    } pd_e;

    typedef struct packed {
        logic              valid;
        logic [NCH-1:0]    wr;
        logic [NCH-1:0]    upd;
        logic [CODE_W-1:0] code;
        logic              pd_set;
        logic [NCH-1:0]    pd_mask;
        pd_e               pd_mode;
        logic              ref_set;
        logic              ref_val;
        logic              srst;
    } cmd_t;
endpackage

// File: rtl/dpc_fall_det.sv
// Falling-edge detector for a level input that is synchronous to clk.
// Assumes the input is already in the clk domain. The history register
// resets high, so an input that is low at reset gives one harmless edge.
module dpc_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic fall
);
    logic prev_q;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sig_n;
    end

    assign fall = prev_q & ~sig_n;
endmodule

// File: rtl/dpc_frame_decode.sv
// Turns a completed 24-bit command word into a decoded command record.
// Assumes frm_busy is high from the first shifted bit up to and including
// the frm_done cycle. A clear edge seen while busy drops that word.
module dpc_frame_decode
    import dpc_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_busy,
    input  logic               frm_done,
    input  logic [FRAME_W-1:0] frm_word,
    input  logic               clr_fall,
    output cmd_t               cmd_o
);
    localparam int               LSB_W     = CODE_W - RES_BITS;
    localparam logic [CODE_W-1:0] CODE_MASK = ~CODE_W'((32'd1 << LSB_W) - 32'd1);

    logic           abort_q;
    logic           accept;
    logic [3:0]     op;
    logic [3:0]     tgt;
    logic [NCH-1:0] tsel;
    logic           tgt_ok;

    // Track a word that was cut by a clear edge until its end or idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                        abort_q <= 1'b0;
        else if (clr_fall && frm_busy && !frm_done) abort_q <= 1'b1;
        else if (frm_done || !frm_busy)    abort_q <= 1'b0;
    end

    assign op     = frm_word[23:20];
    assign tgt    = frm_word[19:16];
    assign accept = frm_done & ~abort_q & ~clr_fall;

    // Build the per-channel select from the target field.
    always_comb begin
        for (int i = 0; i < NCH; i++)
            tsel[i] = (tgt == 4'(i)) || (tgt == TGT_ALL);
    end
    assign tgt_ok = |tsel;

    // Decode the operation into the command record.
    always_comb begin
        cmd_o         = '0;
        cmd_o.code    = frm_word[CODE_W-1:0] & CODE_MASK;
        cmd_o.pd_mask = frm_word[NCH-1:0];
        cmd_o.pd_mode = pd_e'(frm_word[5:4]);
        cmd_o.ref_val = frm_word[0];
        if (accept) begin
            case (op)
                OP_WR_IN: if (tgt_ok) begin
                    cmd_o.valid = 1'b1;
                    cmd_o.wr    = tsel;
                end
                OP_UPD: if (tgt_ok) begin
                    cmd_o.valid = 1'b1;
                    cmd_o.upd   = tsel;
                end
                OP_WR_UPD_ALL: if (tgt_ok) begin
                    cmd_o.valid = 1'b1;
                    cmd_o.wr    = tsel;
                    cmd_o.upd   = '1;
                end
                OP_WR_UPD: if (tgt_ok) begin
                    cmd_o.valid = 1'b1;
                    cmd_o.wr    = tsel;
                    cmd_o.upd   = tsel;
                end
                OP_PWR: begin
                    cmd_o.valid  = 1'b1;
                    cmd_o.pd_set = 1'b1;
                end
                OP_SRST: begin
                    cmd_o.valid = 1'b1;
                    cmd_o.srst  = 1'b1;
                end
                OP_REF: begin
                    cmd_o.valid   = 1'b1;
                    cmd_o.ref_set = 1'b1;
                end
                default: cmd_o.valid = 1'b0;
            endcase
        end
    end

    // R10
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fall && frm_busy && !frm_done) |=> !(frm_done && cmd_o.valid));
endmodule

// File: rtl/dpc_channel.sv
// One converter channel: staging register, output register, waiting flag
// and power-down mode. Assumes all controls are single-cycle qualified
// strobes from the top level. A clear has priority over any write.
module dpc_channel
    import dpc_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              clr,
    input  logic              wr,
    input  logic              upd,
    input  logic [CODE_W-1:0] code,
    input  logic              pass_en,
    input  logic              load_pulse,
    input  logic              pd_set,
    input  pd_e               pd_mode,
    output logic [CODE_W-1:0] dac_code,
    output pd_e               pd_state
);
    localparam int               LSB_W    = CODE_W - RES_BITS;
    localparam logic [CODE_W-1:0] LOW_MASK = CODE_W'((32'd1 << LSB_W) - 32'd1);

    logic [CODE_W-1:0] in_q, dac_q, new_in;
    logic              pend_q, xfer;
    pd_e               pd_q;

    assign new_in = wr ? code : in_q;
    assign xfer   = upd | (wr & pass_en) | (load_pulse & (pend_q | wr));

    // Update the staging and output registers and the waiting flag.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            in_q   <= '0;
            dac_q  <= '0;
            pend_q <= 1'b0;
        end else if (clr) begin
            in_q   <= '0;
            dac_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            in_q <= new_in;
            if (xfer) begin
                dac_q  <= new_in;
                pend_q <= 1'b0;
            end else if (wr) begin
                pend_q <= 1'b1;
            end
        end
    end

    // Hold the power-down mode chosen by software.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) pd_q <= PD_ON;
        else if (pd_set)    pd_q <= pd_mode;
    end

    assign dac_code = dac_q;
    assign pd_state = pd_q;

    // R3
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_q & LOW_MASK) == '0) && ((dac_q & LOW_MASK) == '0));
    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !srst) |=> (in_q == '0 && dac_q == '0));
    // R4
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd || wr || load_pulse || clr || srst) |=> $stable(dac_q));
    // R13
    srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (dac_q == '0 && pd_q == PD_ON));
endmodule

// File: rtl/dac_pair_ctrl.sv
// Top of the dual-channel DAC register controller. It decodes command
// words and gates the load input against the clear input and the clear
// mode. It holds the reference enable and instantiates one channel per
// output. Assumes load_n and clr_n are synchronous to clk.
module dac_pair_ctrl
    import dpc_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frm_busy,
    input  logic        frm_done,
    input  logic [23:0] frm_word,
    input  logic        load_n,
    input  logic        clr_n,
    output logic [15:0] code_a,
    output logic [15:0] code_b,
    output logic [1:0]  pd_a,
    output logic [1:0]  pd_b,
    output logic        ref_en
);
    logic              clr_fall, ld_fall;
    logic              clr_mode_q, ref_q;
    logic              load_pulse, pass_en;
    cmd_t              cmd;
    logic [CODE_W-1:0] codes [NCH];
    pd_e               pds   [NCH];

    dpc_fall_det u_clr_edge (.clk(clk), .rst_n(rst_n), .sig_n(clr_n),  .fall(clr_fall));
    dpc_fall_det u_ld_edge  (.clk(clk), .rst_n(rst_n), .sig_n(load_n), .fall(ld_fall));

    dpc_frame_decode #(.RES_BITS(RES_BITS)) u_dec (
        .clk(clk), .rst_n(rst_n), .frm_busy(frm_busy), .frm_done(frm_done),
        .frm_word(frm_word), .clr_fall(clr_fall), .cmd_o(cmd)
    );

    // Clear mode lasts from a clear edge until the next accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.srst) clr_mode_q <= 1'b0;
        else if (clr_fall)      clr_mode_q <= 1'b1;
        else if (cmd.valid)     clr_mode_q <= 1'b0;
    end

    // Reference enable follows software only.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.srst) ref_q <= 1'b0;
        else if (cmd.ref_set)   ref_q <= cmd.ref_val;
    end

    assign load_pulse = ld_fall & clr_n & ~clr_mode_q;
    assign pass_en    = ~load_n & clr_n;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dpc_channel #(.RES_BITS(RES_BITS)) u_ch (
            .clk(clk), .rst_n(rst_n), .srst(cmd.srst), .clr(clr_fall),
            .wr(cmd.wr[g]), .upd(cmd.upd[g]), .code(cmd.code),
            .pass_en(pass_en), .load_pulse(load_pulse),
            .pd_set(cmd.pd_set & cmd.pd_mask[g]), .pd_mode(cmd.pd_mode),
            .dac_code(codes[g]), .pd_state(pds[g])
        );
    end

    assign code_a = codes[0];
    assign code_b = codes[1];
    assign pd_a   = pds[0];
    assign pd_b   = pds[1];
    assign ref_en = ref_q;

    // R12
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd.ref_set || cmd.srst) |=> $stable(ref_en));
    // R9
    clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !clr_fall && cmd.upd == '0 && !cmd.srst) |=> $stable({code_a, code_b}));
    // R1
    reset_val_chk: assert property (@(posedge clk)
        !rst_n |=> (code_a == '0 && code_b == '0 && !ref_en));
endmodule

// File: tb/dac_pair_ctrl_tb.sv
module dac_pair_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_busy = 1'b0, frm_done = 1'b0;
    logic [23:0] frm_word = '0;
    logic        load_n = 1'b1, clr_n = 1'b1;
    logic [15:0] code_a, code_b;
    logic [1:0]  pd_a, pd_b;
    logic        ref_en;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dac_pair_ctrl #(.RES_BITS(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .frm_busy(frm_busy), .frm_done(frm_done),
        .frm_word(frm_word), .load_n(load_n), .clr_n(clr_n),
        .code_a(code_a), .code_b(code_b), .pd_a(pd_a), .pd_b(pd_b), .ref_en(ref_en)
    );

    // {word, load_n level, expected code_a, expected code_b}
    localparam int NV = 8;
    localparam logic [56:0] VEC [NV] = '{
        {24'h101234, 1'b1, 16'h0000, 16'h0000},
        {24'h200000, 1'b1, 16'h1230, 16'h0000},
        {24'h41ABCD, 1'b1, 16'h1230, 16'hABC0},
        {24'h115555, 1'b1, 16'h1230, 16'hABC0},
        {24'h300FFF, 1'b1, 16'h0FF0, 16'h5550},
        {24'h1FFFFF, 1'b0, 16'hFFF0, 16'hFFF0},
        {24'h121111, 1'b1, 16'hFFF0, 16'hFFF0},
        {24'h902222, 1'b1, 16'hFFF0, 16'hFFF0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [23:0] w);
        frm_busy = 1'b1;
        @(negedge clk);
        @(negedge clk);
        frm_done = 1'b1;
        frm_word = w;
        @(negedge clk);
        frm_done = 1'b0;
        frm_busy = 1'b0;
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        @(negedge clk);
        load_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 power-on state
        check("R1 code_a", code_a, 0);
        check("R1 code_b", code_b, 0);
        check("R1 pd", {pd_a, pd_b}, 0);
        check("R1 ref_en", ref_en, 0);

        // R2 R3 R5 R6 R7 table of command words
        for (int i = 0; i < NV; i++) begin
            load_n = VEC[i][32];
            @(negedge clk);
            send(VEC[i][56:33]);
            check($sformatf("R2/R3/R5/R6/R7 vec %0d code_a", i), code_a, VEC[i][31:16]);
            check($sformatf("R2/R3/R5/R6/R7 vec %0d code_b", i), code_b, VEC[i][15:0]);
            load_n = 1'b1;
            @(negedge clk);
        end

        // R4 simultaneous load of both staged channels
        send(24'h104000);
        send(24'h118000);
        check("R4 staged A held", code_a, 16'hFFF0);
        check("R4 staged B held", code_b, 16'hFFF0);
        pulse_load();
        check("R4 load A", code_a, 16'h4000);
        check("R4 load B", code_b, 16'h8000);
        send(24'h101000);
        pulse_load();
        check("R4 only A waiting A", code_a, 16'h1000);
        check("R4 only A waiting B", code_b, 16'h8000);

        // R11 power-down modes by mask
        send(24'h500011);
        check("R11 pd_a", pd_a, 2'b01);
        check("R11 pd_b", pd_b, 2'b00);
        send(24'h500032);
        check("R11 pd_b float", pd_b, 2'b11);
        check("R11 pd_a kept", pd_a, 2'b01);

        // R12 reference enable
        send(24'h700001);
        check("R12 ref on", ref_en, 1);

        // R8 clear edge
        clr_n = 1'b0;
        @(negedge clk);
        check("R8 code_a", code_a, 0);
        check("R8 code_b", code_b, 0);
        check("R8 pd kept", {pd_a, pd_b}, 4'b0111);
        check("R8 ref kept", ref_en, 1);

        // R9 loads ignored while clear held low
        send(24'h107000);
        pulse_load();
        check("R9 pulse ignored A", code_a, 0);
        load_n = 1'b0;
        @(negedge clk);
        send(24'h116000);
        check("R9 pass ignored B", code_b, 0);
        load_n = 1'b1;
        @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        pulse_load();
        check("R9 later load A", code_a, 16'h7000);
        check("R9 later load B", code_b, 16'h6000);

        // R10 clear during a word aborts it
        frm_busy = 1'b1;
        @(negedge clk);
        clr_n = 1'b0;
        @(negedge clk);
        frm_done = 1'b1;
        frm_word = 24'h403000;
        @(negedge clk);
        frm_done = 1'b0;
        frm_busy = 1'b0;
        clr_n = 1'b1;
        @(negedge clk);
        check("R10 aborted A", code_a, 0);
        send(24'h403000);
        check("R10 next word A", code_a, 16'h3000);

        // R12 reference off
        send(24'h700000);
        check("R12 ref off", ref_en, 0);
        send(24'h700001);

        // R13 software reset
        send(24'h600000);
        check("R13 code_a", code_a, 0);
        check("R13 code_b", code_b, 0);
        check("R13 pd", {pd_a, pd_b}, 0);
        check("R13 ref_en", ref_en, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule